// File: doc/BRIEF.md
# Shared Unit Forced-Lock Arbiter

This block decides which media engine currently holds each unit in a small pool of shared processing units, such as scaler or format-converter units. Engines come in two classes. Decode engine `i` is wired to unit `i >> 1`, so two decode engines share each unit. Enhancement engine `i` is wired to unit `i`. An engine holds its request high to lock its unit and drops the request to release it.

Before an engine is reset, the reset sequencer raises that engine's forced-lock input. This freezes the ownership of the engine's unit. A unit that is locked stays with its owner. A unit that is free refuses every new request. Once the freeze is stable, an acknowledge bit rises. The sequencer then reads the usage bit to learn whether the unit must be reset together with the engine. A per-unit reset input unlocks a unit without lifting a freeze.

Engines are ranked by a single index. Decode engines come first, `0..N_DEC-1`, and enhancement engines follow at `N_DEC..N_DEC+N_ENH-1`. When engines contend for a unit, the lowest index wins.

Top module: `sfc_lock_arbiter`

## Requirements
- R1: Decode engine `i` requests and freezes unit `i >> 1`. Enhancement engine `j` requests and freezes unit `j`. Requests on different units never block each other.
- R2: A decode engine whose bit is clear in `dec_access_i` has its request and forced lock ignored. Its status word reads `2'b00`.
- R3: A free, unfrozen unit with at least one request is locked at the next clock edge. It is locked to the requester with the lowest engine index.
- R4: When the owner drops its request and the unit is not frozen, the unit becomes free at the next edge. Another waiting requester can be granted at the edge after that.
- R5: While a forced lock is held on a locked unit, the unit keeps its owner, even if the owner drops its request.
- R6: While a forced lock is held on a free unit, the unit stays free and ignores all requests. A waiting request is granted at the first edge after the freeze ends.
- R7: An engine's acknowledge rises after `ACK_DLY` consecutive clock edges with its forced lock held. It drops at the first edge at which the forced lock is low.
- R8: Decode status word bit 0 is usage and bit 1 is acknowledge. Enhancement engines report acknowledge on `enh_ack_o[j]` and usage on `enh_usage_o[j]`. Usage is 1 exactly when the unit is locked to that engine.
- R9: A unit stays frozen while any engine wired to it holds a forced lock. Clearing the forced lock of an engine that does not hold the freeze has no effect on the unit.
- R10: A pulse on `unit_rst_i[u]` frees unit `u` at the next edge. An active freeze remains, so the unit then stays free until the freeze ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_access_i | input | N_DEC | Decode engines allowed to reach a unit |
| dec_req_i | input | N_DEC | Decode engine lock requests (level) |
| dec_force_i | input | N_DEC | Decode engine forced-lock inputs |
| enh_req_i | input | N_ENH | Enhancement engine lock requests (level) |
| enh_force_i | input | N_ENH | Enhancement engine forced-lock inputs |
| unit_rst_i | input | N_UNIT | Per-unit reset, unlocks the unit |
| dec_status_o | output | N_DEC x 2 | Per decode engine: bit 0 usage, bit 1 acknowledge |
| enh_ack_o | output | N_ENH | Enhancement engine acknowledge |
| enh_usage_o | output | N_ENH | Enhancement engine usage |

## Verification
The bench builds the block with four decode engines, two enhancement engines and two units, so each unit has two decode engines and one enhancement engine competing for it. This makes three-way priority, mapping and cross-class freezes observable. `ACK_DLY` is set to 3, so the acknowledge has a visible low phase while the freeze is already in force. The access mask is driven at run time, which lets a masked engine attempt both a lock and a freeze on a unit that another engine then uses.

// File: rtl/sfc_lock_pkg.sv
package sfc_lock_pkg;
  // Engine index: decode engines first, then enhancement engines.
  function automatic int unsigned unit_of(input int unsigned eng, input int unsigned n_dec);
    return (eng < n_dec) ? (eng >> 1) : (eng - n_dec);
  endfunction
endpackage

// File: rtl/sfc_ack_timer.sv
module sfc_ack_timer #(
  parameter int ACK_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  output logic ack_o
);
  localparam int CW  = (ACK_DLY > 1) ? $clog2(ACK_DLY) : 1;
  localparam int LIM = ACK_DLY - 1;

  logic [CW-1:0] cnt_q;
  logic          ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (!force_i) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      if (cnt_q != CW'(LIM)) cnt_q <= cnt_q + 1'b1;
      ack_q <= (cnt_q == CW'(LIM));
    end
  end

  assign ack_o = ack_q;

  // R7
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_i |=> !ack_o);
endmodule

// File: rtl/sfc_unit_arb.sv
module sfc_unit_arb #(
  parameter int N_ENG = 6,
  localparam int EW = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENG-1:0] req_i,
  input  logic             frozen_i,
  input  logic             unit_rst_i,
  output logic             locked_o,
  output logic [EW-1:0]    owner_o
);
  logic          locked_q;
  logic [EW-1:0] owner_q;
  logic [EW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int e = N_ENG - 1; e >= 0; e--) begin
      if (req_i[e]) pick = EW'(e);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
    end else if (unit_rst_i) begin
      locked_q <= 1'b0;
    end else if (!frozen_i) begin
      if (locked_q && !req_i[owner_q]) begin
        locked_q <= 1'b0;
      end else if (!locked_q && |req_i) begin
        locked_q <= 1'b1;
        owner_q  <= pick;
      end
    end
  end

  assign locked_o = locked_q;
  assign owner_o  = owner_q;

  // R5
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_i && !unit_rst_i) |=> ($stable(locked_q) && (!locked_q || $stable(owner_q))));

  // R3
  grant_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && !frozen_i && !unit_rst_i && |req_i) |=> locked_q);

  // R10
  unit_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_rst_i |=> !locked_q);
endmodule

// File: rtl/sfc_lock_arbiter.sv
module sfc_lock_arbiter
  import sfc_lock_pkg::*;
#(
  parameter int N_DEC   = 4,
  parameter int N_ENH   = 2,
  parameter int N_UNIT  = 2,
  parameter int ACK_DLY = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_DEC-1:0]      dec_access_i,
  input  logic [N_DEC-1:0]      dec_req_i,
  input  logic [N_DEC-1:0]      dec_force_i,
  input  logic [N_ENH-1:0]      enh_req_i,
  input  logic [N_ENH-1:0]      enh_force_i,
  input  logic [N_UNIT-1:0]     unit_rst_i,
  output logic [N_DEC-1:0][1:0] dec_status_o,
  output logic [N_ENH-1:0]      enh_ack_o,
  output logic [N_ENH-1:0]      enh_usage_o
);
  localparam int N_ENG = N_DEC + N_ENH;
  localparam int EW    = (N_ENG > 1) ? $clog2(N_ENG) : 1;

  logic [N_ENG-1:0] req_v, force_v, use_v, ack_v;
  logic [N_ENG-1:0] unit_req [N_UNIT];
  logic [N_ENG-1:0] unit_use [N_UNIT];
  logic [N_UNIT-1:0] unit_frozen, unit_locked;
  logic [EW-1:0]     unit_owner [N_UNIT];

  // Masked decode engines are cut off from the pool.
  assign req_v   = {enh_req_i,   dec_req_i   & dec_access_i};
  assign force_v = {enh_force_i, dec_force_i & dec_access_i};

  always_comb begin
    for (int u = 0; u < N_UNIT; u++) begin
      unit_req[u]    = '0;
      unit_frozen[u] = 1'b0;
      for (int e = 0; e < N_ENG; e++) begin
        if (unit_of(e, N_DEC) == u) begin
          unit_req[u][e] = req_v[e];
          unit_frozen[u] = unit_frozen[u] | force_v[e];
        end
      end
    end
  end

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    sfc_unit_arb #(.N_ENG(N_ENG)) i_arb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (unit_req[u]),
      .frozen_i   (unit_frozen[u]),
      .unit_rst_i (unit_rst_i[u]),
      .locked_o   (unit_locked[u]),
      .owner_o    (unit_owner[u])
    );

    always_comb begin
      for (int e = 0; e < N_ENG; e++) begin
        unit_use[u][e] = (unit_of(e, N_DEC) == u) && use_v[e];
      end
    end

    // R8
    single_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(unit_use[u]));
  end

  always_comb begin
    use_v = '0;
    for (int e = 0; e < N_ENG; e++) begin
      for (int u = 0; u < N_UNIT; u++) begin
        if (unit_of(e, N_DEC) == u)
          use_v[e] = unit_locked[u] && (unit_owner[u] == EW'(e));
      end
    end
  end

  for (genvar e = 0; e < N_ENG; e++) begin : g_eng
    sfc_ack_timer #(.ACK_DLY(ACK_DLY)) i_ack (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .force_i (force_v[e]),
      .ack_o   (ack_v[e])
    );
  end

  for (genvar i = 0; i < N_DEC; i++) begin : g_dec_st
    assign dec_status_o[i] = {ack_v[i], use_v[i]} & {2{dec_access_i[i]}};
  end

  assign enh_ack_o   = ack_v[N_ENG-1:N_DEC];
  assign enh_usage_o = use_v[N_ENG-1:N_DEC];
endmodule

// File: tb/test_sfc_lock_arbiter.sv
module test_sfc_lock_arbiter;
  localparam int N_DEC = 4, N_ENH = 2, N_UNIT = 2, ACK_DLY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_DEC-1:0] dec_access = '1, dec_req = '0, dec_force = '0;
  logic [N_ENH-1:0] enh_req = '0, enh_force = '0;
  logic [N_UNIT-1:0] unit_rst = '0;
  logic [N_DEC-1:0][1:0] dec_status;
  logic [N_ENH-1:0] enh_ack, enh_usage;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sfc_lock_arbiter #(.N_DEC(N_DEC), .N_ENH(N_ENH), .N_UNIT(N_UNIT), .ACK_DLY(ACK_DLY))
  i_sfc_lock_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .dec_access_i(dec_access), .dec_req_i(dec_req),
    .dec_force_i(dec_force), .enh_req_i(enh_req), .enh_force_i(enh_force),
    .unit_rst_i(unit_rst), .dec_status_o(dec_status), .enh_ack_o(enh_ack),
    .enh_usage_o(enh_usage)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    dec_req = '0; dec_force = '0; enh_req = '0; enh_force = '0; unit_rst = '0;
    dec_access = '1;
    step(2);
  endtask

  task automatic t_reset();
    chk("R8 reset dec status", 8'(dec_status), 8'h00);
    chk("R8 reset enh", {4'h0, enh_ack, enh_usage}, 8'h00);
  endtask

  task automatic t_map_prio();
    dec_req = 4'b1111; enh_req = 2'b11;
    step(1);
    // R3 dec0 wins unit0, dec2 wins unit1
    chk("R3 priority all", 8'(dec_status), 8'b00_01_00_01);
    chk("R3 enh lose", {6'h0, enh_usage}, 8'h00);
    idle();
    dec_req = 4'b0010; enh_req = 2'b11;
    step(1);
    // R1 dec1 and enh0 share unit0, enh1 alone on unit1
    chk("R1 dec1 owns unit0", 8'(dec_status), 8'b00_00_01_00);
    chk("R1 enh1 owns unit1", {6'h0, enh_usage}, 8'h02);
    idle();
  endtask

  task automatic t_release();
    dec_req = 4'b0011;
    step(1);
    chk("R4 dec0 owns", 8'(dec_status), 8'b00_00_00_01);
    dec_req = 4'b0010;
    step(1);
    chk("R4 free after drop", 8'(dec_status), 8'h00);
    step(1);
    chk("R4 dec1 granted", 8'(dec_status), 8'b00_00_01_00);
    idle();
  endtask

  task automatic t_freeze_locked();
    enh_req = 2'b01;
    step(1);
    dec_force = 4'b0001; enh_req = 2'b00;
    step(1);
    chk("R5 owner kept", {6'h0, enh_usage}, 8'h01);
    chk("R7 ack not yet", {6'h0, dec_status[0]}, 8'h00);
    step(ACK_DLY - 2);
    chk("R7 ack still low", {6'h0, dec_status[0]}, 8'h00);
    step(1);
    chk("R7 R8 ack bit1", {6'h0, dec_status[0]}, 8'h02);
    chk("R5 owner kept late", {6'h0, enh_usage}, 8'h01);
    dec_force = '0;
    step(1);
    chk("R7 ack drop", {6'h0, dec_status[0]}, 8'h00);
    chk("R5 release after clear", {6'h0, enh_usage}, 8'h00);
    idle();
  endtask

  task automatic t_freeze_free();
    enh_force = 2'b10; dec_req = 4'b0100;
    step(ACK_DLY + 1);
    chk("R6 refused", {6'h0, dec_status[2]}, 8'h00);
    chk("R8 enh ack", {6'h0, enh_ack}, 8'h02);
    enh_force = '0;
    step(1);
    chk("R6 granted after", {6'h0, dec_status[2]}, 8'h01);
    idle();
  endtask

  task automatic t_multi_force();
    dec_req = 4'b0001;
    step(1);
    dec_force = 4'b0011; dec_req = '0;
    step(1);
    dec_force = 4'b0001;
    step(1);
    chk("R9 still frozen", {6'h0, dec_status[0][0], dec_status[1][0]}, 8'h02);
    dec_force = '0;
    step(1);
    chk("R9 released", {6'h0, dec_status[0]}, 8'h00);
    idle();
  endtask

  task automatic t_access();
    dec_access = 4'b0111; dec_force = 4'b1000; dec_req = 4'b1000;
    step(ACK_DLY + 1);
    chk("R2 masked status", {6'h0, dec_status[3]}, 8'h00);
    dec_req = 4'b1100;
    step(1);
    chk("R2 masked force no freeze", {6'h0, dec_status[2]}, 8'h01);
    chk("R2 masked still zero", {6'h0, dec_status[3]}, 8'h00);
    idle();
  endtask

  task automatic t_unit_rst();
    dec_req = 4'b0001;
    step(1);
    enh_force = 2'b01; unit_rst = 2'b01;
    step(1);
    unit_rst = '0;
    chk("R10 unlocked", {7'h0, dec_status[0][0]}, 8'h00);
    step(2);
    chk("R10 freeze kept", {7'h0, dec_status[0][0]}, 8'h00);
    enh_force = '0;
    step(1);
    chk("R10 regrant", {7'h0, dec_status[0][0]}, 8'h01);
    idle();
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_map_prio();
    t_release();
    t_freeze_locked();
    t_freeze_free();
    t_multi_force();
    t_access();
    t_unit_rst();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule